// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Decoder

This block receives the serial byte stream a PS/2 keyboard sends on its two open-collector lines, clock and data. It turns that stream into key events. Both lines are asynchronous to the system clock. Each one is brought into the system domain through a synchronizer and then passed through a glitch filter. The receiver samples data on each filtered falling edge of the keyboard clock and assembles an 11-bit frame: a low start bit, eight data bits least significant first, an odd parity bit and a high stop bit.

Received bytes go to a prefix tracker. A release (break) prefix of F0 and an extended prefix of E0, in either order, are remembered rather than reported. The next ordinary byte is then emitted as a single key event carrying its scan code and an extended flag and a break flag, with a one-cycle valid strobe. A frame that fails its parity or stop check raises a one-cycle error strobe instead, and any pending prefixes are dropped. If a frame stalls partway, a watchdog returns the receiver to idle. The block only listens: it never drives the lines and does not map scan codes to characters.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset, `key_valid_o`, `frame_err_o`, `key_code_o`, `key_ext_o` and `key_brk_o` are all 0.
- R2: A frame has a start bit of 0, then data bits 0 to 7 (LSB first), then a parity bit that makes the nine bits' count of ones odd, then a stop bit of 1. A good frame whose byte is not E0 or F0 produces one event with `key_code_o` equal to the byte. Unless prefixes are pending, that event has `key_ext_o`=0 and `key_brk_o`=0. The event appears one cycle after the receiver accepts the byte.
- R3: The byte F0 produces no event itself. It makes the next ordinary byte's event carry `key_brk_o`=1.
- R4: The byte E0 produces no event itself. It makes the next ordinary byte's event carry `key_ext_o`=1. The sequence E0 F0 code gives one event with both flags set.
- R5: A key code received repeatedly gives one make event per frame, with no merging of repeats.
- R6: A frame with wrong parity raises `frame_err_o` for one cycle and produces no key event.
- R7: A frame with a stop bit of 0 raises `frame_err_o` for one cycle and produces no key event.
- R8: A frame error discards any pending E0 or F0 prefix, so the next ordinary byte is reported as a plain make.
- R9: If no keyboard clock falling edge arrives for `TIMEOUT_CYC` system cycles during a frame, the partial frame is dropped silently and the receiver waits for a new start bit.
- R10: While the receiver is idle, a keyboard clock falling edge with data high does not start a frame.
- R11: A keyboard clock pulse shorter than `FILT_LEN` system cycles is not counted as an edge.
- R12: `key_valid_o` and `frame_err_o` are single-cycle strobes and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_data_i | input | 1 | Keyboard data line, asynchronous |
| key_valid_o | output | 1 | One-cycle strobe: a key event is present |
| key_code_o | output | 8 | Base scan code of the event |
| key_ext_o | output | 1 | Event was preceded by the E0 prefix |
| key_brk_o | output | 1 | Event is a key release (F0 prefix seen) |
| frame_err_o | output | 1 | One-cycle strobe: parity or stop bit failure |

## Verification
The bench sends several kinds of frames and compares each result with a behavioural prefix model:
- Plain make codes tell apart the bit order and the parity polarity.
- Back-to-back repeats of one code show that repeats are not merged.
- F0, E0 and E0 F0 sequences show how the flags combine and that prefix bytes stay silent.
- Frames with a bad parity bit or a bad stop bit, each followed by a plain code, show that errors are flagged and that pending prefixes are dropped.
- A stalled partial frame checks the watchdog.
- A low clock pulse with data high in idle checks that such a pulse cannot start a frame.
- A short clock glitch in mid-frame checks the filter.

In the last three cases, a receiver that fails would misalign the next good frame, and the resulting code would differ from the expected one.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PAY_BITS  = BYTE_W + 1;  // data + parity
  localparam int unsigned FRAME_LEN = BYTE_W + 3;  // start, data, parity, stop
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hE0;
  localparam logic [BYTE_W-1:0] PFX_BRK = 8'hF0;

  typedef enum logic [1:0] {
    ST_NONE,
    ST_EXT,
    ST_BRK,
    ST_EXT_BRK
  } pfx_state_e;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // change level only after FILT_LEN agreeing samples
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kclk_i,
  input  logic              kdat_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              err_o
);
  localparam int unsigned WD_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(TIMEOUT_CYC - 1);

  logic                kclk_q;
  logic                fall;
  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [PAY_BITS-1:0] sh_q;
  logic [WD_W-1:0]     wd_q;
  logic                vld_q, err_q;
  logic [BYTE_W-1:0]   byte_q;
  logic                frame_ok;

  assign fall     = kclk_q & ~kclk_i;
  assign frame_ok = (^sh_q) & kdat_i;  // odd parity over data+parity, stop high

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kclk_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      wd_q   <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      kclk_q <= kclk_i;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      if (fall) begin
        wd_q <= '0;
        if (!busy_q) begin
          if (!kdat_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
          end
        end else if (cnt_q == STOP_IDX) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          if (frame_ok) begin
            vld_q  <= 1'b1;
            byte_q <= sh_q[BYTE_W-1:0];
          end else begin
            err_q  <= 1'b1;
          end
        end else begin
          sh_q  <= {kdat_i, sh_q[PAY_BITS-1:1]};
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (busy_q) begin
        if (wd_q == WD_LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          wd_q   <= '0;
        end else begin
          wd_q <= wd_q + WD_W'(1);
        end
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign err_o      = err_q;
endmodule

// File: rtl/ps2_prefix_fsm.sv
module ps2_prefix_fsm
  import ps2_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              err_i,
  output logic              ev_vld_o,
  output logic [BYTE_W-1:0] ev_code_o,
  output logic              ev_ext_o,
  output logic              ev_brk_o,
  output logic              ev_err_o
);
  pfx_state_e        st_q;
  logic              has_ext, has_brk;
  logic              vld_q, ext_q, brk_q, err_q;
  logic [BYTE_W-1:0] code_q;

  assign has_ext = (st_q == ST_EXT) || (st_q == ST_EXT_BRK);
  assign has_brk = (st_q == ST_BRK) || (st_q == ST_EXT_BRK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_NONE;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      ext_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= err_i;
      if (err_i) begin
        st_q <= ST_NONE;
      end else if (byte_vld_i) begin
        if (byte_i == PFX_EXT) begin
          st_q <= has_brk ? ST_EXT_BRK : ST_EXT;
        end else if (byte_i == PFX_BRK) begin
          st_q <= has_ext ? ST_EXT_BRK : ST_BRK;
        end else begin
          vld_q  <= 1'b1;
          code_q <= byte_i;
          ext_q  <= has_ext;
          brk_q  <= has_brk;
          st_q   <= ST_NONE;
        end
      end
    end
  end

  assign ev_vld_o  = vld_q;
  assign ev_code_o = code_q;
  assign ev_ext_o  = ext_q;
  assign ev_brk_o  = brk_q;
  assign ev_err_o  = err_q;
endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder
  import ps2_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  output logic              key_valid_o,
  output logic [BYTE_W-1:0] key_code_o,
  output logic              key_ext_o,
  output logic              key_brk_o,
  output logic              frame_err_o
);
  localparam int unsigned N_LINES = 2;  // [0] clock, [1] data

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic               rx_byte_vld;
  logic [BYTE_W-1:0]  rx_byte;
  logic               rx_err;

  assign raw_lines = {ps2_data_i, ps2_clk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ps2_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  ps2_frame_rx #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kclk_i    (filt_lines[0]),
    .kdat_i    (filt_lines[1]),
    .byte_vld_o(rx_byte_vld),
    .byte_o    (rx_byte),
    .err_o     (rx_err)
  );

  ps2_prefix_fsm u_pfx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_vld_i(rx_byte_vld),
    .byte_i    (rx_byte),
    .err_i     (rx_err),
    .ev_vld_o  (key_valid_o),
    .ev_code_o (key_code_o),
    .ev_ext_o  (key_ext_o),
    .ev_brk_o  (key_brk_o),
    .ev_err_o  (frame_err_o)
  );
endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk
  import ps2_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_valid_o,
  input logic [BYTE_W-1:0] key_code_o,
  input logic              frame_err_o,
  input logic              rx_byte_vld,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_err
);
  a_r12_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  a_r12_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_valid_o && frame_err_o));

  a_r2_event_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_vld && rx_byte != PFX_EXT && rx_byte != PFX_BRK)
      |=> (key_valid_o && key_code_o == $past(rx_byte)));

  a_r3_brk_prefix_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_vld && rx_byte == PFX_BRK) |=> !key_valid_o);

  a_r4_ext_prefix_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_vld && rx_byte == PFX_EXT) |=> !key_valid_o);

  a_r6_err_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err |=> (frame_err_o && !key_valid_o));
endmodule

bind ps2_key_decoder ps2_key_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_valid_o(key_valid_o),
  .key_code_o (key_code_o),
  .frame_err_o(frame_err_o),
  .rx_byte_vld(rx_byte_vld),
  .rx_byte    (rx_byte),
  .rx_err     (rx_err)
);

// File: tb/tb_ps2_key_decoder.sv
`timescale 1ns/1ps
module tb_ps2_key_decoder;
  localparam int TIMEOUT = 200;
  localparam int QTR     = 10;   // system cycles per quarter of keyboard bit
  localparam int FLEN    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kclk = 1'b1;
  logic kdat = 1'b1;
  logic       key_valid, key_ext, key_brk, frame_err;
  logic [7:0] key_code;

  always #2.5 clk = ~clk;  // 200 MHz

  ps2_key_decoder #(
    .SYNC_STAGES(2),
    .FILT_LEN   (FLEN),
    .TIMEOUT_CYC(TIMEOUT)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ps2_clk_i  (kclk),
    .ps2_data_i (kdat),
    .key_valid_o(key_valid),
    .key_code_o (key_code),
    .key_ext_o  (key_ext),
    .key_brk_o  (key_brk),
    .frame_err_o(frame_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reference: pending prefixes and expected outputs
  bit        m_ext = 1'b0, m_brk = 1'b0;
  logic [9:0] exp_q[$];  // {ext, brk, code}
  string      exp_req_q[$];
  string      err_req_q[$];

  function automatic void model_byte(input logic [7:0] b, input bit ok, input string req);
    if (!ok) begin
      err_req_q.push_back(req);
      m_ext = 1'b0; m_brk = 1'b0;
    end else if (b == 8'hE0) m_ext = 1'b1;
    else if (b == 8'hF0) m_brk = 1'b1;
    else begin
      exp_q.push_back({m_ext, m_brk, b});
      exp_req_q.push_back(req);
      m_ext = 1'b0; m_brk = 1'b0;
    end
  endfunction

  // per-clock comparison of the event and error streams
  always @(negedge clk) if (rst_n && !done) begin
    if (key_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R3/R4: unexpected event act=%h ext=%0d brk=%0d exp=none",
                 key_code, key_ext, key_brk);
      end else begin
        logic [9:0] e;
        string r;
        e = exp_q.pop_front();
        r = exp_req_q.pop_front();
        if ({key_ext, key_brk, key_code} !== e) begin
          n_bad++;
          $display("FAIL %s: event act={ext %0d brk %0d code %h} exp={ext %0d brk %0d code %h}",
                   r, key_ext, key_brk, key_code, e[9], e[8], e[7:0]);
        end
      end
    end
    if (frame_err) begin
      n_chk++;
      if (err_req_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R7: unexpected frame error act=1 exp=0");
      end else void'(err_req_q.pop_front());
    end
    if (key_valid && frame_err) begin
      n_bad++;
      $display("FAIL R12: valid and error together act=1 exp=0");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives one bit: data set in high phase, then a full low phase
  task automatic send_bit(input bit v, input bit glitch);
    if (glitch) begin
      kclk = 1'b0; wait_cyc(FLEN - 2); kclk = 1'b1; wait_cyc(2);
    end
    kdat = v;
    wait_cyc(QTR);
    kclk = 1'b0;
    wait_cyc(2 * QTR);
    kclk = 1'b1;
    wait_cyc(QTR);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                            input int glitch_at, input string req);
    logic [10:0] f;
    f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    model_byte(b, !(bad_par || bad_stop), req);
    for (int i = 0; i < 11; i++) send_bit(f[i], i == glitch_at);
    kdat = 1'b1;
    wait_cyc(60);
  endtask

  task automatic send(input logic [7:0] b, input string req);
    send_frame(b, 1'b0, 1'b0, -1, req);
  endtask

  task automatic drain(input string req);
    wait_cyc(40);
    n_chk++;
    if (exp_q.size() != 0 || err_req_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: outstanding expectations act=%0d pending exp=0",
               req, exp_q.size() + err_req_q.size());
      exp_q.delete(); exp_req_q.delete(); err_req_q.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    // R1 reset state
    n_chk++;
    if (key_valid !== 1'b0 || frame_err !== 1'b0 || key_code !== 8'h00 ||
        key_ext !== 1'b0 || key_brk !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset outputs act=%0d%0d%h%0d%0d exp=0000000",
               key_valid, frame_err, key_code, key_ext, key_brk);
    end
    rst_n = 1'b1;
    wait_cyc(20);

    // R2 plain make codes, varied bit patterns
    send(8'h1C, "R2"); send(8'h81, "R2"); send(8'h7E, "R2"); send(8'h00, "R2");
    drain("R2");
    // R5 repeats
    send(8'h29, "R5"); send(8'h29, "R5"); send(8'h29, "R5");
    drain("R5");
    // R3 break
    send(8'hF0, "R3"); send(8'h1C, "R3");
    drain("R3");
    // R4 extended make and extended break
    send(8'hE0, "R4"); send(8'h75, "R4");
    send(8'hE0, "R4"); send(8'hF0, "R4"); send(8'h75, "R4");
    drain("R4");
    // R6 parity error
    send_frame(8'h33, 1'b1, 1'b0, -1, "R6"); send(8'h34, "R6");
    drain("R6");
    // R7 stop error
    send_frame(8'h44, 1'b0, 1'b1, -1, "R7"); send(8'h45, "R7");
    drain("R7");
    // R8 error drops pending prefixes
    send(8'hE0, "R8"); send(8'hF0, "R8");
    send_frame(8'h5A, 1'b1, 1'b0, -1, "R8"); send(8'h5A, "R8");
    drain("R8");
    // R9 stalled partial frame, then a good frame
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    wait_cyc(3 * TIMEOUT);
    send(8'h66, "R9");
    drain("R9");
    // R10 clock low pulse with data high in idle, good frame right after
    kdat = 1'b1; kclk = 1'b0; wait_cyc(2 * QTR); kclk = 1'b1; wait_cyc(QTR);
    send(8'h4B, "R10");
    drain("R10");
    // R11 short clock glitches inside a frame
    send_frame(8'h3C, 1'b0, 1'b0, 3, "R11");
    send_frame(8'hC3, 1'b0, 1'b0, 9, "R11");
    drain("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule